// File: doc/BRIEF.md
# Trigger Delay and Pulse-Pattern Shaper

This block receives a one-bit trigger impulse, already aligned to the system clock. It holds the impulse back by a programmable number of whole clock cycles. It then plays a user bit pattern onto an active-low accept line, one bit per cycle, for every cycle in which the delayed impulse is high. The result is the time-domain convolution of the delayed impulse stream with the pattern. Where two copies of the pattern overlap, they merge by logical OR.

Two uses follow from this. A pattern with a single set bit gives a one-cycle accept pulse. A pattern with several set bits gives a burst, such as two accepts a fixed distance apart for each trigger. Moving the set bit within the pattern shifts the output in time without a reset.

The delay value is taken only while reset is held, so a new delay needs a reset to take effect. The pattern is read live on every cycle.

Top module: `trig_shaper`

## Requirements
- R1: While `rst` is high, `accept_n` is high. Reset clears all pending impulses, so an impulse taken before reset never produces an accept after reset is released.
- R2: Let D be the captured delay and let the pattern be 1000000000. An impulse sampled at clock edge k drives `accept_n` low for exactly one cycle, in the cycle after edge k+D. This holds for every D from 0 to 255.
- R3: `dly_set` is sampled only on edges where `rst` is high. A change to `dly_set` after reset is released does not change the output timing.
- R4: The pattern is emitted most-significant bit first. After edge k+D+a, for a from 0 to 9, the output reflects `pattern[9-a]`. A pattern of 1100011100 appears on the line in that same order.
- R5: `accept_n` is low exactly where the emitted bit is 1 and high elsewhere. A pattern of 1000010000 yields two one-cycle accepts five cycles apart for each impulse.
- R6: Moving the single set bit k places toward the LSB delays the accept by k more cycles. For example, 0010000000 behaves like 1000000000 with two cycles of extra delay.
- R7: Responses to impulses that overlap in time combine by OR. After edge t, the line is low if any earlier impulse asks for a 1 at that time.
- R8: Every cycle in which `impulse` is sampled high launches its own copy of the pattern. With D=0 and `pattern[9]` set, the output in the cycle after such an edge is low.
- R9: The pattern is read on every edge, with no reset needed. The output after edge t uses the pattern value present at edge t.
- R10: When the pattern sampled at an edge is all zeros, `accept_n` is high after that edge, whatever impulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also the capture strobe for `dly_set` |
| impulse | input | 1 | Clock-aligned trigger impulse, active high |
| dly_set | input | 8 | Delay in whole clock cycles, binary, captured during reset |
| pattern | input | 10 | Response bit pattern; bit 9 is emitted first |
| accept_n | output | 1 | Shaped accept to the modules, active low, registered |

## Verification
The bench builds the block with its default widths: an 8-bit delay and a 10-bit pattern. This puts both ends of the delay range within reach, from a zero-cycle tap that passes the impulse straight into the shaper to the deepest 255-cycle tap. Each run is long enough to follow the whole ten-bit response past the largest delay. The stimulus includes overlapping and multi-cycle impulses and a pattern swap in mid-response. It also changes the delay input after reset, to show that only the value captured during reset counts.

// File: rtl/trig_shaper_pkg.sv
package trig_shaper_pkg;
    // Default widths shared by the shaper, its checker and its bench
    localparam int DLY_W_DEF = 8;
    localparam int PAT_W_DEF = 10;

    // Largest delay selectable with a given delay width
    function automatic int max_delay(input int dly_w);
        return (1 << dly_w) - 1;
    endfunction
endpackage

// File: rtl/tsh_delay_line.sv
// Shift pipeline of past impulses; the output tap is chosen by a value
// captured while reset is held. Needs DLY_W >= 2.
module tsh_delay_line #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] dly_set,
    input  logic             imp_in,
    output logic             imp_out
);
    localparam int DEPTH = (1 << DLY_W) - 1;

    typedef struct packed {
        logic [DLY_W-1:0] tap;
        logic [DEPTH-1:0] pipe;
    } dl_state_t;

    dl_state_t  st_d, st_q;
    logic [DEPTH:0] taps;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.tap  = dly_set;
            st_d.pipe = '0;
        end else begin
            st_d.pipe = {st_q.pipe[DEPTH-2:0], imp_in};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // taps[k] is the impulse from k cycles ago; tap 0 is the live input
    assign taps    = {st_q.pipe, imp_in};
    assign imp_out = taps[st_q.tap];
endmodule

// File: rtl/tsh_convolver.sv
// Convolves the delayed impulse with the response pattern, MSB first.
module tsh_convolver #(
    parameter int PAT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             imp_in,
    input  logic [PAT_W-1:0] pattern,
    output logic             accept_n
);
    typedef struct packed {
        logic [PAT_W-2:0] hist;
        logic             acc_n;
    } cv_state_t;

    cv_state_t        st_d, st_q;
    logic [PAT_W-1:0] pat_rev;
    logic [PAT_W-1:0] window;

    // Age a of the impulse pairs with pattern bit PAT_W-1-a
    for (genvar gi = 0; gi < PAT_W; gi++) begin : g_rev
        assign pat_rev[gi] = pattern[PAT_W-1-gi];
    end

    assign window = {st_q.hist, imp_in};

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.hist  = '0;
            st_d.acc_n = 1'b1;
        end else begin
            st_d.hist  = window[PAT_W-2:0];
            st_d.acc_n = ~|(window & pat_rev);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign accept_n = st_q.acc_n;
endmodule

// File: rtl/trig_shaper.sv
module trig_shaper
    import trig_shaper_pkg::*;
#(
    parameter int DLY_W = DLY_W_DEF,
    parameter int PAT_W = PAT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             impulse,
    input  logic [DLY_W-1:0] dly_set,
    input  logic [PAT_W-1:0] pattern,
    output logic             accept_n
);
    logic dly_imp;

    tsh_delay_line #(.DLY_W(DLY_W)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .dly_set (dly_set),
        .imp_in  (impulse),
        .imp_out (dly_imp)
    );

    tsh_convolver #(.PAT_W(PAT_W)) u_conv (
        .clk      (clk),
        .rst      (rst),
        .imp_in   (dly_imp),
        .pattern  (pattern),
        .accept_n (accept_n)
    );
endmodule

// File: rtl/trig_shaper_chk.sv
module trig_shaper_chk #(
    parameter int DLY_W = 8,
    parameter int PAT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             impulse,
    input logic [DLY_W-1:0] dly_set,
    input logic [PAT_W-1:0] pattern,
    input logic             accept_n
);
    localparam int QW = $clog2((1 << DLY_W) + PAT_W + 1) + 1;

    logic [DLY_W-1:0] lat_dly;
    logic [QW-1:0]    quiet;
    logic             rst_prev;

    // Cycles since the latest impulse, saturating; port-level delay capture
    always_ff @(posedge clk) begin
        rst_prev <= rst;
        if (rst) begin
            lat_dly <= dly_set;
            quiet   <= '1;
        end else if (impulse) begin
            quiet <= '0;
        end else if (quiet != '1) begin
            quiet <= quiet + 1'b1;
        end
    end

    // R1
    always @(posedge clk) begin
        if (rst_prev) begin
            idle_after_reset_chk: assert (accept_n);
        end
    end

    // R3
    resp_window_chk: assert property (@(posedge clk) disable iff (rst)
        (quiet > (QW'(lat_dly) + QW'(PAT_W - 1))) |-> accept_n);

    // R8
    level_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (impulse && pattern[PAT_W-1] && lat_dly == '0) |=> !accept_n);

    // R10
    zero_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (pattern == '0) |=> accept_n);
endmodule

bind trig_shaper trig_shaper_chk #(.DLY_W(DLY_W), .PAT_W(PAT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .impulse  (impulse),
    .dly_set  (dly_set),
    .pattern  (pattern),
    .accept_n (accept_n)
);

// File: tb/trig_shaper_test.sv
module trig_shaper_test;
    localparam int DLY_W = 8;
    localparam int PAT_W = 10;
    localparam int NVEC  = 10;
    localparam int MAXT  = 320;

    typedef struct packed {
        logic [7:0]  dly;
        logic [7:0]  dly2;
        logic [9:0]  pat;
        logic [9:0]  pat2;
        logic [8:0]  sw;
        logic [31:0] stim;
    } vec_t;

    // {captured delay, delay after release, pattern, later pattern, switch cycle, impulse bits}
    localparam vec_t VEC [NVEC] = '{
        '{8'd0,   8'd0,   10'b1000000000, 10'b1000000000, 9'd511, 32'h0000_0001}, // R2 zero delay
        '{8'd255, 8'd255, 10'b1000000000, 10'b1000000000, 9'd511, 32'h0000_0001}, // R2 deepest tap
        '{8'd5,   8'd5,   10'b1100011100, 10'b1100011100, 9'd511, 32'h0000_0001}, // R4
        '{8'd3,   8'd3,   10'b1000010000, 10'b1000010000, 9'd511, 32'h0000_0001}, // R5
        '{8'd3,   8'd3,   10'b0010000000, 10'b0010000000, 9'd511, 32'h0000_0001}, // R6
        '{8'd2,   8'd2,   10'b1010000000, 10'b1010000000, 9'd511, 32'h0000_000B}, // R7
        '{8'd4,   8'd4,   10'b1000000001, 10'b1000000001, 9'd511, 32'h0000_0007}, // R8
        '{8'd6,   8'd1,   10'b1000000000, 10'b1000000000, 9'd511, 32'h0000_0004}, // R3
        '{8'd1,   8'd1,   10'b1000000000, 10'b0000000001, 9'd3,   32'h0000_0101}, // R9
        '{8'd7,   8'd7,   10'b0000000000, 10'b0000000000, 9'd511, 32'h0000_00FF}  // R10
    };

    logic             clk;
    logic             rst;
    logic             impulse;
    logic [DLY_W-1:0] dly_set;
    logic [PAT_W-1:0] pattern;
    logic             accept_n;

    int checks;
    int fails;

    logic             imp_a [MAXT];
    logic [PAT_W-1:0] pat_a [MAXT];

    trig_shaper #(.DLY_W(DLY_W), .PAT_W(PAT_W)) uut (
        .clk      (clk),
        .rst      (rst),
        .impulse  (impulse),
        .dly_set  (dly_set),
        .pattern  (pattern),
        .accept_n (accept_n)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    function automatic string tag_of(input int i);
        case (i)
            0, 1:    return "R2";
            2:       return "R4";
            3:       return "R5";
            4:       return "R6";
            5:       return "R7";
            6:       return "R8";
            7:       return "R3";
            8:       return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input int t);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: accept_n=%b expected %b", tag, t, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input int idx);
        vec_t v;
        int   len;
        logic exp_n;
        v = VEC[idx];
        len = int'(v.dly) + 48;
        rst = 1'b1;
        impulse = 1'b0;
        dly_set = v.dly;
        pattern = v.pat;
        step();
        step();
        rst = 1'b0;
        dly_set = v.dly2;
        for (int t = 0; t < len; t++) begin
            impulse = (t < 32) ? v.stim[t] : 1'b0;
            pattern = (t >= int'(v.sw)) ? v.pat2 : v.pat;
            imp_a[t] = impulse;
            pat_a[t] = pattern;
            step();
            // Expected from the convolution rule with the delay captured in reset
            exp_n = 1'b1;
            for (int e = 0; e <= t; e++) begin
                int a;
                a = t - e - int'(v.dly);
                if (imp_a[e] && a >= 0 && a < PAT_W && pat_a[t][PAT_W-1-a])
                    exp_n = 1'b0;
            end
            check(tag_of(idx), accept_n, exp_n, t);
        end
    endtask

    initial begin
        checks = 0;
        fails = 0;
        rst = 1'b1;
        impulse = 1'b0;
        dly_set = '0;
        pattern = '0;

        // R1: held inactive during reset even with impulse and a full pattern
        @(negedge clk);
        impulse = 1'b1;
        pattern = '1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R1", accept_n, 1'b1, i);
        end

        // R1: reset in flight clears the pending impulse
        impulse = 1'b0;
        dly_set = 8'd3;
        step();
        rst = 1'b0;
        impulse = 1'b1;
        step();
        impulse = 1'b0;
        step();
        rst = 1'b1;
        step();
        check("R1", accept_n, 1'b1, 0);
        step();
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step();
            check("R1", accept_n, 1'b1, i);
        end

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            run_case(i);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, got running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule